// File: doc/BRIEF.md
# Address-masked GPIO with interrupts

This block is an eight-line general-purpose I/O peripheral on a simple synchronous register bus with byte-wide data. Each line is independently an input or an output. The data port is a window of word addresses: the address bits of an access act as a per-line mask, so one bus write can change any chosen subset of output lines without a read-modify-write, and a read returns only the lines that the address picks out.

Every input line passes through a two-flop synchroniser. Interrupt detection is configured per line with three bit registers: one picks level or edge sensing, one turns on detection of both edges, and one picks high level or rising edge against low level or falling edge. Edge events are latched until software writes a one to the clear register. Level status simply follows the synchronised pin. Raw status, enable-masked status and a single registered interrupt output are provided.

Top module: `maskgpio`

## Requirements
- R1: After reset every control register, the output data and every status bit are 0, `pinOutEn` is 0 (all lines inputs) and `irqOut` is 0.
- R2: The direction register at byte offset 0x400 is read/write; bit n = 1 makes line n an output, and `pinOutEn` equals the register contents.
- R3: A write to the data window (byte offsets 0x000 to 0x3FC) changes output value bit n only when address bit n+2 is 1 and line n is an output; a data write to a line set as input is ignored, so its value must be written again after the line becomes an output.
- R4: A read of the data window returns, for each line whose address bit n+2 is 1, the driven value if the line is an output or the synchronised pin if it is an input, and 0 for every line whose address bit is 0.
- R5: With the sense bit (offset 0x404) at 1 a line is level-sensed: its raw status is 1 while the synchronised pin equals the event bit (offset 0x40C; 1 = high, 0 = low), and no clear is needed.
- R6: With the sense bit at 0 and the both-edges bit (offset 0x408) at 0, a rising edge (event bit 1) or a falling edge (event bit 0) of the synchronised pin sets a latched raw status bit; the opposite edge does not.
- R7: With the sense bit at 0 and the both-edges bit at 1, either edge sets the latched status bit whatever the event bit holds.
- R8: Raw status reads at 0x414; masked status at 0x418 reads raw status AND the enable register at 0x410.
- R9: Writing the clear register at 0x41C clears each latched edge status bit whose data bit is 1 and leaves bits written 0; when a new edge and a clear hit the same bit in the same cycle the bit stays set.
- R10: `irqOut` is a registered OR of all masked status bits.
- R11: Read data appears on `busRdata` in the cycle after the read access and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| pinIn | input | 8 | Asynchronous pin levels |
| pinOut | output | 8 | Output value per line |
| pinOutEn | output | 8 | Output enable per line (1 = drive) |
| irqOut | output | 1 | Combined interrupt |

## Verification
On every cycle the assertions check that a data write leaves input and unselected lines untouched, that no pin output moves without a data write, that a masked read returns zero on unselected lines, that a detected edge always latches even against a clear, that a clear removes written bits, and that the interrupt never rises without some enable set. Only the bench scenarios show the full mask sweep across direction patterns, the read-back of driven and sampled values, and the per-mode sensing behaviour of each line: level following, single-edge selectivity, both-edge detection ignoring the event bit, and the exact cycle in which a clear and a new edge collide.

// File: rtl/maskgpio_pkg.sv
package maskgpio_pkg;

  // Register page word indices (byte offset 0x400 + 4*index)
  localparam logic [7:0] IDX_DIR    = 8'h00;
  localparam logic [7:0] IDX_SENSE  = 8'h01;
  localparam logic [7:0] IDX_BOTH   = 8'h02;
  localparam logic [7:0] IDX_EVENT  = 8'h03;
  localparam logic [7:0] IDX_EN     = 8'h04;
  localparam logic [7:0] IDX_RAW    = 8'h05;
  localparam logic [7:0] IDX_MASKED = 8'h06;
  localparam logic [7:0] IDX_CLR    = 8'h07;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH,
    RD_EVENT, RD_EN, RD_RAW, RD_MASKED
  } readSel_e;

  typedef struct packed {
    logic     wrData;
    logic     wrDir;
    logic     wrSense;
    logic     wrBoth;
    logic     wrEvent;
    logic     wrEn;
    logic     wrClr;
    logic     rdStrobe;
    readSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/maskgpio_sync.sv
module maskgpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage <= '0;
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) begin
        stage[s] <= stage[s-1];
      end
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/maskgpio_ctrl.sv
module maskgpio_ctrl
  import maskgpio_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 12
) (
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  output busStrobe_t           strb,
  output logic [NUM_LINES-1:0] lineMask
);

  localparam int PAGE_W = ADDR_W - 10;

  logic [PAGE_W-1:0] pageSel;
  logic [7:0]        regIdx;
  logic              inData;
  logic              inRegs;

  assign pageSel  = busAddr[ADDR_W-1:10];
  assign regIdx   = busAddr[9:2];
  assign inData   = (pageSel == '0);
  assign inRegs   = (pageSel == PAGE_W'(1));
  assign lineMask = busAddr[NUM_LINES+1:2];

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (busSel) begin
      strb.rdStrobe = !busWrite;
      if (inData) begin
        strb.wrData = busWrite;
        strb.rdSel  = RD_DATA;
      end else if (inRegs) begin
        case (regIdx)
          IDX_DIR:    begin strb.wrDir   = busWrite; strb.rdSel = RD_DIR;   end
          IDX_SENSE:  begin strb.wrSense = busWrite; strb.rdSel = RD_SENSE; end
          IDX_BOTH:   begin strb.wrBoth  = busWrite; strb.rdSel = RD_BOTH;  end
          IDX_EVENT:  begin strb.wrEvent = busWrite; strb.rdSel = RD_EVENT; end
          IDX_EN:     begin strb.wrEn    = busWrite; strb.rdSel = RD_EN;    end
          IDX_RAW:    strb.rdSel = RD_RAW;
          IDX_MASKED: strb.rdSel = RD_MASKED;
          IDX_CLR:    strb.wrClr = busWrite;
          default:    strb.rdSel = RD_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/maskgpio_dp.sv
module maskgpio_dp
  import maskgpio_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strb,
  input  logic [NUM_LINES-1:0] lineMask,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOutEn,
  output logic [NUM_LINES-1:0] rdata,
  output logic                 irqOut
);

  logic [NUM_LINES-1:0] dirReg, dataReg, senseReg, bothReg, eventReg, enReg;
  logic [NUM_LINES-1:0] syncNow, syncPrev;
  logic [NUM_LINES-1:0] trigVec, edgeLatch, rawStatus, maskedStatus;
  logic [NUM_LINES-1:0] dataWen;
  logic [NUM_LINES-1:0] rdMux;

  maskgpio_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (syncNow)
  );

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg   <= '0;
      senseReg <= '0;
      bothReg  <= '0;
      eventReg <= '0;
      enReg    <= '0;
    end else begin
      if (strb.wrDir)   dirReg   <= wdata;
      if (strb.wrSense) senseReg <= wdata;
      if (strb.wrBoth)  bothReg  <= wdata;
      if (strb.wrEvent) eventReg <= wdata;
      if (strb.wrEn)    enReg    <= wdata;
    end
  end

  // Masked output data: only selected output lines take the write
  assign dataWen = strb.wrData ? (lineMask & dirReg) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) dataReg <= '0;
    else       dataReg <= (dataReg & ~dataWen) | (wdata & dataWen);
  end

  assign pinOut   = dataReg;
  assign pinOutEn = dirReg;

  // Previous synchronised sample for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) syncPrev <= '0;
    else       syncPrev <= syncNow;
  end

  // Per-line interrupt sensing
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic riseEv;
    logic fallEv;

    always_comb begin
      riseEv = syncNow[i] & ~syncPrev[i];
      fallEv = ~syncNow[i] & syncPrev[i];
      if (senseReg[i])     trigVec[i] = 1'b0;
      else if (bothReg[i]) trigVec[i] = riseEv | fallEv;
      else if (eventReg[i]) trigVec[i] = riseEv;
      else                 trigVec[i] = fallEv;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                      edgeLatch[i] <= 1'b0;
      else if (senseReg[i])           edgeLatch[i] <= 1'b0;
      else if (trigVec[i])            edgeLatch[i] <= 1'b1;
      else if (strb.wrClr && wdata[i]) edgeLatch[i] <= 1'b0;
    end

    assign rawStatus[i] = senseReg[i] ? (syncNow[i] == eventReg[i]) : edgeLatch[i];
  end

  assign maskedStatus = rawStatus & enReg;

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |maskedStatus;
  end

  // Read path
  always_comb begin
    case (strb.rdSel)
      RD_DATA:   rdMux = ((dirReg & dataReg) | (~dirReg & syncNow)) & lineMask;
      RD_DIR:    rdMux = dirReg;
      RD_SENSE:  rdMux = senseReg;
      RD_BOTH:   rdMux = bothReg;
      RD_EVENT:  rdMux = eventReg;
      RD_EN:     rdMux = enReg;
      RD_RAW:    rdMux = rawStatus;
      RD_MASKED: rdMux = maskedStatus;
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdata <= '0;
    else if (strb.rdStrobe) rdata <= rdMux;
  end

  // R3: a data write touches only selected output lines
  p_input_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> (((pinOut ^ $past(pinOut)) & ~$past(dirReg & lineMask)) == '0));

  // R3: without a data write the driven values stay put
  p_no_write_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrData |=> $stable(pinOut));

  // R4: unselected lines read as zero
  p_unmasked_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStrobe && strb.rdSel == RD_DATA) |=> ((rdata & ~$past(lineMask)) == '0));

  // R9: a detected edge always latches, even against a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|trigVec) |=> ((edgeLatch & $past(trigVec)) == $past(trigVec)));

  // R9: written-one bits without a new edge are cleared
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((edgeLatch & $past(wdata & ~trigVec)) == '0));

  // R10: the interrupt needs at least one enabled line
  p_irq_enable_r10: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ($past(enReg) != '0));

endmodule

// File: rtl/maskgpio.sv
module maskgpio
  import maskgpio_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [NUM_LINES-1:0] busWdata,
  output logic [NUM_LINES-1:0] busRdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOutEn,
  output logic                 irqOut
);

  busStrobe_t           strb;
  logic [NUM_LINES-1:0] lineMask;

  maskgpio_ctrl #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb),
    .lineMask (lineMask)
  );

  maskgpio_dp #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lineMask (lineMask),
    .wdata    (busWdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOutEn (pinOutEn),
    .rdata    (busRdata),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/maskgpio_test.sv
module maskgpio_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinOut;
  logic [7:0]  pinOutEn;
  logic        irqOut;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_ALL    = 12'h3FC;
  localparam logic [11:0] A_DIR    = 12'h400;
  localparam logic [11:0] A_SENSE  = 12'h404;
  localparam logic [11:0] A_BOTH   = 12'h408;
  localparam logic [11:0] A_EVENT  = 12'h40C;
  localparam logic [11:0] A_EN     = 12'h410;
  localparam logic [11:0] A_RAW    = 12'h414;
  localparam logic [11:0] A_MASKED = 12'h418;
  localparam logic [11:0] A_CLR    = 12'h41C;

  maskgpio uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOutEn(pinOutEn), .irqOut(irqOut)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] trigModel(input logic [7:0] oldP, input logic [7:0] newP,
                                           input logic sense, input logic both, input logic ev);
    logic [7:0] rise, fall;
    rise = newP & ~oldP;
    fall = ~newP & oldP;
    if (sense) return 8'h00;
    if (both)  return rise | fall;
    return ev ? rise : fall;
  endfunction

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] latchM, pins, en, rawExp;
    logic sense, both, ev;
    string tag;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(3);

    // R1: reset state
    chk("R1 pinOutEn", pinOutEn, 8'h00);
    chk("R1 pinOut", pinOut, 8'h00);
    chk("R1 irqOut", {7'd0, irqOut}, 8'h00);
    chk("R11 rdata before read", busRdata, 8'h00);
    rd(A_DIR, d);    chk("R1 dir", d, 8'h00);
    rd(A_SENSE, d);  chk("R1 sense", d, 8'h00);
    rd(A_BOTH, d);   chk("R1 both", d, 8'h00);
    rd(A_EVENT, d);  chk("R1 event", d, 8'h00);
    rd(A_EN, d);     chk("R1 enable", d, 8'h00);
    rd(A_RAW, d);    chk("R1 raw", d, 8'h00);
    rd(A_MASKED, d); chk("R1 masked", d, 8'h00);
    rd(A_ALL, d);    chk("R1 data", d, 8'h00);

    // R2: direction register and output enable
    wr(A_DIR, 8'hA5);
    rd(A_DIR, d); chk("R2 dir readback", d, 8'hA5);
    chk("R2 pinOutEn", pinOutEn, 8'hA5);
    idle(2);
    chk("R11 rdata holds", busRdata, 8'hA5);

    // R3: a write to input lines is ignored and not remembered
    wr(A_DIR, 8'h00);
    wr(A_ALL, 8'hFF);
    wr(A_DIR, 8'hFF);
    chk("R3 input write ignored", pinOut, 8'h00);
    wr(A_ALL, 8'h96);
    chk("R3 write after switch", pinOut, 8'h96);

    // R3/R4: mask sweep across direction patterns
    pinIn = 8'h5A;
    idle(4);
    for (int di = 0; di < 4; di++) begin
      logic [7:0] dir;
      dir = (di == 0) ? 8'h00 : (di == 1) ? 8'hA5 : (di == 2) ? 8'hFF : 8'h3C;
      wr(A_DIR, dir);
      for (int m = 0; m < 256; m++) begin
        logic [7:0] wd, drv, full;
        wd = 8'(m) ^ dir ^ 8'h3C;
        wr(A_ALL, 8'h00);
        wr({2'b00, 8'(m), 2'b00}, wd);
        drv = wd & 8'(m) & dir;
        chk("R3 masked write", pinOut & dir, drv);
        full = drv | (~dir & pinIn);
        rd(A_ALL, d);
        chk("R4 full read", d, full);
        rd({2'b00, 8'(m), 2'b00}, d);
        chk("R4 masked read", d, full & 8'(m));
      end
    end

    // Interrupt modes: 0 level high, 1 level low, 2 rising, 3 falling, 4 both
    wr(A_DIR, 8'h00);
    pinIn = 8'h00;
    idle(6);
    for (int mode = 0; mode < 5; mode++) begin
      sense = (mode < 2);
      both  = (mode == 4);
      ev    = (mode == 0) || (mode == 2) || (mode == 4);
      tag   = (mode < 2) ? "R5" : (mode < 4) ? "R6" : "R7";
      for (int i = 0; i < 8; i++) begin
        en = (i % 2 == 1) ? 8'hAA : 8'h55;
        pins = 8'h00;
        pinIn = pins;
        wr(A_SENSE, {8{sense}});
        wr(A_BOTH, {8{both}});
        wr(A_EVENT, {8{ev}});
        wr(A_EN, en);
        wr(A_CLR, 8'hFF);
        idle(6);
        latchM = 8'h00;
        for (int step = 0; step < 4; step++) begin
          logic [7:0] oldP;
          oldP = pins;
          if (step == 0) pins = 8'(1) << i;
          if (step == 2) pins = 8'h00;
          if (step == 0 || step == 2) begin
            pinIn = pins;
            idle(6);
            latchM = latchM | trigModel(oldP, pins, sense, both, ev);
          end else begin
            wr(A_CLR, 8'hFF);
            latchM = 8'h00;
          end
          rawExp = sense ? (ev ? pins : ~pins) : latchM;
          rd(A_RAW, d);
          chk((step % 2 == 1) ? "R9 raw after clear" : tag, d, rawExp);
          rd(A_MASKED, d);
          chk("R8 masked", d, rawExp & en);
          idle(2);
          chk("R10 irqOut", {7'd0, irqOut}, {7'd0, |(rawExp & en)});
        end
      end
    end

    // R9: clear of zero bits leaves latched bits alone
    wr(A_SENSE, 8'h00); wr(A_BOTH, 8'hFF); wr(A_EN, 8'hFF);
    wr(A_CLR, 8'hFF);
    pinIn = 8'h0F;
    idle(6);
    wr(A_CLR, 8'h05);
    rd(A_RAW, d); chk("R9 partial clear", d, 8'h0A);
    wr(A_CLR, 8'hFF);
    rd(A_RAW, d); chk("R9 full clear", d, 8'h00);

    // R9: edge and clear in the same cycle, the edge wins
    wr(A_BOTH, 8'h00); wr(A_EVENT, 8'hFF);
    pinIn = 8'h00;
    idle(6);
    wr(A_CLR, 8'hFF);
    @(negedge clk);
    pinIn = 8'h10;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = A_CLR; busWdata = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    rd(A_RAW, d); chk("R9 set wins over clear", d, 8'h10);
    idle(2);
    chk("R10 irqOut after collision", {7'd0, irqOut}, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule